// File: doc/BRIEF.md
# NAND flash command sequencer

This block runs the command, address and data phases of a raw 8-bit NAND flash bus for a host that issues one request at a time. A request names an operation (device reset, identification read or single-page read), one of four chips and a 24-bit page number. The sequencer selects the chip, drives command and address bytes with their latch strobes, waits for the ready/busy line where the operation needs it, and hands each returned byte to the host over a valid/ready byte stream.

Waiting on ready is bounded. A short settle window comes first, then a fixed number of polls. If the device never reports ready, the sequencer raises a sticky error flag, drops the chip select and ends the operation normally. A single-cycle done pulse closes every operation, including one that timed out. The page transfer length is a parameter. Its default is 4314 bytes: a 4096-byte data area followed by a 218-byte spare area.

Top module: `nand_seq`

## Requirements
- R1: While reset is held and right after it, all chip selects, cle_o, ale_o, we_o, re_o, done_o, err_o and dat_valid_o are 0, and req_ready_o is 1.
- R2: During an operation nand_ce_o equals one-hot 1<<req_chip_i (bit n selects chip n). It is 4'b0000 whenever the sequencer is idle, and from the done pulse onward.
- R3: Opcode 0 (reset) drives command 0xFF and then waits for ready. It reads no data.
- R4: Opcode 1 (identify) drives command 0x90, then one address byte 0x00, and then delivers exactly five bytes to the host in device order.
- R5: Opcode 2 (page read) drives command 0x00, then address bytes 0x00, 0x00, page[7:0], page[15:8], page[23:16], then command 0x30, waits for ready, and then delivers XFER_LEN bytes (default 4314) in device order.
- R6: A page read asserts no read strobe before the device reports ready after command 0x30.
- R7: cle_o is high only on command cycles and ale_o only on address cycles. The two are never high together, and we_o is high for exactly one cycle per driven byte, only together with one of them.
- R8: If nand_rb_i stays low through SETTLE cycles plus POLL_MAX polls, err_o is set, no data is read, the chip select is dropped and done_o still pulses.
- R9: err_o stays set through later successful operations and is cleared only by rst_ni.
- R10: While dat_valid_o is high and dat_ready_i is low, dat_o holds its value and dat_valid_o stays high. No byte is lost or repeated.
- R11: done_o is a one-cycle pulse, issued once per operation after the last byte has been accepted. Requests presented while an operation runs are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request present |
| req_ready_o | output | 1 | Sequencer idle, request taken on this cycle |
| req_op_i | input | 2 | 0 reset, 1 identify, 2 page read (3 treated as reset) |
| req_chip_i | input | 2 | Chip index |
| req_page_i | input | 24 | Page (row) number |
| done_o | output | 1 | One-cycle end-of-operation pulse |
| err_o | output | 1 | Sticky ready-timeout flag |
| nand_ce_o | output | 4 | One-hot chip select, active high |
| nand_cle_o | output | 1 | Command latch enable |
| nand_ale_o | output | 1 | Address latch enable |
| nand_we_o | output | 1 | Write strobe, one cycle per driven byte |
| nand_re_o | output | 1 | Read strobe; byte on nand_dq_i captured at this edge |
| nand_dq_o | output | 8 | Byte driven to the device |
| nand_dq_i | input | 8 | Byte returned by the device |
| nand_rb_i | input | 1 | Ready (1) / busy (0) |
| dat_valid_o | output | 1 | Output byte valid |
| dat_ready_i | input | 1 | Host accepts byte |
| dat_o | output | 8 | Output byte |

## Verification
The byte fetch from the device and the byte handoff to the host can happen in the same cycle: the read strobe fires when the output register is empty or is being drained. The bench drives dat_ready_i at random rates (30 %, 50 %, 100 %) during full-length page reads, so fetch and drain collide on many cycles. It compares every accepted byte against the device model's pattern, which is computed from the requested page, and checks that the received count matches. Any dropped or repeated byte, or a byte that changes while stalled, shows up as a data or count mismatch, or as a hold violation.

// File: rtl/nand_seq_pkg.sv
package nand_seq_pkg;
  typedef enum logic [1:0] {
    OP_RESET = 2'd0,
    OP_IDENT = 2'd1,
    OP_PAGE  = 2'd2
  } op_e;

  typedef enum logic [2:0] {
    ST_IDLE, ST_CMD1, ST_ADDR, ST_CMD2, ST_WAIT, ST_READ, ST_FINISH
  } state_e;

  localparam logic [7:0] CMD_RESET = 8'hFF;
  localparam logic [7:0] CMD_IDENT = 8'h90;
  localparam logic [7:0] CMD_RD_LO = 8'h00;
  localparam logic [7:0] CMD_RD_HI = 8'h30;
  localparam int IDENT_BYTES = 5;
  localparam int PAGE_ADDR_BYTES = 5;
  localparam int PAGE_W = 24;
  localparam int CHIPS = 4;
  localparam int CHIP_W = $clog2(CHIPS);
endpackage

// File: rtl/nand_seq_wait.sv
module nand_seq_wait #(
  parameter int SETTLE   = 4,
  parameter int POLL_MAX = 8192
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic rb_i,
  output logic fin_o,
  output logic tmo_o
);
  localparam int LIMIT = SETTLE + POLL_MAX;
  localparam int CW    = $clog2(LIMIT + 1);

  logic          active_q;
  logic [CW-1:0] cnt_q;

  // ready is only sampled once the settle window has elapsed
  assign fin_o = active_q && (cnt_q >= CW'(SETTLE)) && rb_i;
  assign tmo_o = active_q && !fin_o && (cnt_q == CW'(LIMIT - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      cnt_q    <= '0;
    end else if (start_i) begin
      active_q <= 1'b1;
      cnt_q    <= '0;
    end else if (active_q) begin
      if (fin_o || tmo_o) active_q <= 1'b0;
      else                cnt_q    <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/nand_seq_obuf.sv
module nand_seq_obuf #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] data_i,
  input  logic         ready_i,
  output logic         valid_o,
  output logic [W-1:0] data_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      data_o  <= '0;
    end else if (load_i) begin
      valid_o <= 1'b1;
      data_o  <= data_i;
    end else if (ready_i) begin
      valid_o <= 1'b0;
    end
  end
endmodule

// File: rtl/nand_seq_ctrl.sv
module nand_seq_ctrl
  import nand_seq_pkg::*;
#(
  parameter int XFER_LEN = 4314
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  input  logic [1:0]        req_op_i,
  input  logic [CHIP_W-1:0] req_chip_i,
  input  logic [PAGE_W-1:0] req_page_i,
  output logic              req_ready_o,
  output logic              wait_start_o,
  input  logic              wait_fin_i,
  input  logic              wait_tmo_i,
  input  logic              buf_valid_i,
  input  logic              buf_ready_i,
  output logic              rd_o,
  output logic [CHIPS-1:0]  ce_o,
  output logic              cle_o,
  output logic              ale_o,
  output logic              we_o,
  output logic [7:0]        dq_o,
  output logic              done_o,
  output logic              err_o
);
  localparam int CW = $clog2(XFER_LEN + 1);

  state_e            state_q;
  op_e               op_q;
  logic [CHIP_W-1:0] chip_q;
  logic [PAGE_W-1:0] page_q;
  logic [CW-1:0]     cnt_q;
  logic              err_q;
  logic              addr_last;
  logic [CW-1:0]     last_idx;

  function automatic op_e decode(input logic [1:0] code);
    case (code)
      2'd1:    return OP_IDENT;
      2'd2:    return OP_PAGE;
      default: return OP_RESET;
    endcase
  endfunction

  assign addr_last = (op_q == OP_PAGE) ? (cnt_q == CW'(PAGE_ADDR_BYTES - 1))
                                       : (cnt_q == '0);
  assign last_idx  = (op_q == OP_IDENT) ? CW'(IDENT_BYTES - 1) : CW'(XFER_LEN - 1);

  // fetch when the output register is empty or draining this cycle
  assign rd_o         = (state_q == ST_READ) && (!buf_valid_i || buf_ready_i);
  assign req_ready_o  = (state_q == ST_IDLE);
  assign done_o       = (state_q == ST_FINISH) && !buf_valid_i;
  assign err_o        = err_q;
  assign wait_start_o = ((state_q == ST_CMD1) && (op_q == OP_RESET)) || (state_q == ST_CMD2);

  always_comb begin
    cle_o = (state_q == ST_CMD1) || (state_q == ST_CMD2);
    ale_o = (state_q == ST_ADDR);
    we_o  = cle_o || ale_o;
    ce_o  = '0;
    if (state_q != ST_IDLE && state_q != ST_FINISH) ce_o[chip_q] = 1'b1;
    dq_o = 8'h00;
    case (state_q)
      ST_CMD1: begin
        case (op_q)
          OP_IDENT: dq_o = CMD_IDENT;
          OP_PAGE:  dq_o = CMD_RD_LO;
          default:  dq_o = CMD_RESET;
        endcase
      end
      ST_CMD2: dq_o = CMD_RD_HI;
      ST_ADDR: begin
        if (op_q == OP_PAGE) begin
          case (cnt_q)
            CW'(2):  dq_o = page_q[7:0];
            CW'(3):  dq_o = page_q[15:8];
            CW'(4):  dq_o = page_q[23:16];
            default: dq_o = 8'h00;
          endcase
        end
      end
      default: dq_o = 8'h00;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      op_q    <= OP_RESET;
      chip_q  <= '0;
      page_q  <= '0;
      cnt_q   <= '0;
      err_q   <= 1'b0;
    end else begin
      case (state_q)
        ST_IDLE: if (req_valid_i) begin
          op_q    <= decode(req_op_i);
          chip_q  <= req_chip_i;
          page_q  <= req_page_i;
          cnt_q   <= '0;
          state_q <= ST_CMD1;
        end
        ST_CMD1: begin
          cnt_q   <= '0;
          state_q <= (op_q == OP_RESET) ? ST_WAIT : ST_ADDR;
        end
        ST_ADDR: begin
          if (addr_last) begin
            cnt_q   <= '0;
            state_q <= (op_q == OP_PAGE) ? ST_CMD2 : ST_READ;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        ST_CMD2: state_q <= ST_WAIT;
        ST_WAIT: begin
          if (wait_fin_i) begin
            cnt_q   <= '0;
            state_q <= (op_q == OP_RESET) ? ST_FINISH : ST_READ;
          end else if (wait_tmo_i) begin
            err_q   <= 1'b1;
            state_q <= ST_FINISH;
          end
        end
        ST_READ: if (rd_o) begin
          if (cnt_q == last_idx) state_q <= ST_FINISH;
          else                   cnt_q   <= cnt_q + 1'b1;
        end
        ST_FINISH: if (!buf_valid_i) state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/nand_seq.sv
module nand_seq
  import nand_seq_pkg::*;
#(
  parameter int XFER_LEN = 4314,
  parameter int SETTLE   = 4,
  parameter int POLL_MAX = 8192
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic [1:0]        req_op_i,
  input  logic [CHIP_W-1:0] req_chip_i,
  input  logic [PAGE_W-1:0] req_page_i,
  output logic              done_o,
  output logic              err_o,
  output logic [CHIPS-1:0]  nand_ce_o,
  output logic              nand_cle_o,
  output logic              nand_ale_o,
  output logic              nand_we_o,
  output logic              nand_re_o,
  output logic [7:0]        nand_dq_o,
  input  logic [7:0]        nand_dq_i,
  input  logic              nand_rb_i,
  output logic              dat_valid_o,
  input  logic              dat_ready_i,
  output logic [7:0]        dat_o
);
  logic wait_start, wait_fin, wait_tmo;

  nand_seq_ctrl #(.XFER_LEN(XFER_LEN)) ctrl_i (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .req_valid_i  (req_valid_i),
    .req_op_i     (req_op_i),
    .req_chip_i   (req_chip_i),
    .req_page_i   (req_page_i),
    .req_ready_o  (req_ready_o),
    .wait_start_o (wait_start),
    .wait_fin_i   (wait_fin),
    .wait_tmo_i   (wait_tmo),
    .buf_valid_i  (dat_valid_o),
    .buf_ready_i  (dat_ready_i),
    .rd_o         (nand_re_o),
    .ce_o         (nand_ce_o),
    .cle_o        (nand_cle_o),
    .ale_o        (nand_ale_o),
    .we_o         (nand_we_o),
    .dq_o         (nand_dq_o),
    .done_o       (done_o),
    .err_o        (err_o)
  );

  nand_seq_wait #(.SETTLE(SETTLE), .POLL_MAX(POLL_MAX)) wait_i (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (wait_start),
    .rb_i    (nand_rb_i),
    .fin_o   (wait_fin),
    .tmo_o   (wait_tmo)
  );

  nand_seq_obuf #(.W(8)) obuf_i (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .load_i  (nand_re_o),
    .data_i  (nand_dq_i),
    .ready_i (dat_ready_i),
    .valid_o (dat_valid_o),
    .data_o  (dat_o)
  );
endmodule

// File: rtl/nand_seq_chk.sv
module nand_seq_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       req_ready_o,
  input logic       done_o,
  input logic       err_o,
  input logic [3:0] nand_ce_o,
  input logic       nand_cle_o,
  input logic       nand_ale_o,
  input logic       nand_we_o,
  input logic       dat_valid_o,
  input logic       dat_ready_i,
  input logic [7:0] dat_o
);
  a_r7_latch_excl: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(nand_cle_o && nand_ale_o));
  a_r7_we_with_latch: assert property (@(posedge clk_i) disable iff (!rst_ni)
    nand_we_o |-> (nand_cle_o || nand_ale_o));
  a_r2_ce_onehot: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(nand_ce_o));
  a_r2_idle_no_ce: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_ready_o |-> (nand_ce_o == 4'b0000));
  a_r11_done_no_ce: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (nand_ce_o == 4'b0000));
  a_r11_done_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  a_r9_err_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |=> err_o);
  a_r10_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dat_valid_o && !dat_ready_i) |=> (dat_valid_o && $stable(dat_o)));
endmodule

bind nand_seq nand_seq_chk chk_i (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .req_ready_o (req_ready_o),
  .done_o      (done_o),
  .err_o       (err_o),
  .nand_ce_o   (nand_ce_o),
  .nand_cle_o  (nand_cle_o),
  .nand_ale_o  (nand_ale_o),
  .nand_we_o   (nand_we_o),
  .dat_valid_o (dat_valid_o),
  .dat_ready_i (dat_ready_i),
  .dat_o       (dat_o)
);

// File: tb/nand_seq_tb_top.sv
module nand_seq_tb_top;
  localparam int LEN = 4314;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic        req_valid = 1'b0, req_ready;
  logic [1:0]  req_op = 2'd0;
  logic [1:0]  req_chip = 2'd0;
  logic [23:0] req_page = '0;
  logic        done, err;
  logic [3:0]  ce;
  logic        cle, ale, we, re;
  logic [7:0]  dq_o, dq_i;
  logic        rb;
  logic        dat_valid, dat_ready = 1'b0;
  logic [7:0]  dat;

  nand_seq dut_i (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(req_valid), .req_ready_o(req_ready),
    .req_op_i(req_op), .req_chip_i(req_chip), .req_page_i(req_page),
    .done_o(done), .err_o(err), .nand_ce_o(ce), .nand_cle_o(cle), .nand_ale_o(ale),
    .nand_we_o(we), .nand_re_o(re), .nand_dq_o(dq_o), .nand_dq_i(dq_i), .nand_rb_i(rb),
    .dat_valid_o(dat_valid), .dat_ready_i(dat_ready), .dat_o(dat)
  );

  int errs = 0, checks = 0;

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [7:0] id_byte(input int k);
    case (k)
      0: return 8'h5A;
      1: return 8'hC3;
      2: return 8'h1E;
      3: return 8'h77;
      default: return 8'h09;
    endcase
  endfunction

  function automatic logic [7:0] page_byte(input logic [23:0] p, input int k);
    return 8'(p[7:0] + 8'(k * 3) + 8'(k >> 8)) ^ p[15:8] ^ p[23:16];
  endfunction

  // ---------------- NAND model ----------------
  int         busy_len = 0;
  bit         m_stuck = 1'b0;
  int         m_busy = 0;
  bit         m_idmode = 1'b0;
  int         m_idx = 0;
  int         m_acnt = 0;
  logic [7:0] m_addr [5];
  int         re_busy_bad = 0;

  assign rb   = (m_busy == 0) && !m_stuck;
  assign dq_i = m_idmode ? id_byte(m_idx) : page_byte({m_addr[4], m_addr[3], m_addr[2]}, m_idx);

  initial for (int i = 0; i < 5; i++) m_addr[i] = 8'h00;

  always @(posedge clk) begin
    if (we && cle) begin
      case (dq_o)
        8'hFF: m_busy <= busy_len;
        8'h90: begin m_idmode <= 1'b1; m_idx <= 0; m_acnt <= 0; end
        8'h00: m_acnt <= 0;
        8'h30: begin m_idmode <= 1'b0; m_idx <= 0; m_busy <= busy_len; end
        default: ;
      endcase
    end else if (we && ale) begin
      if (m_acnt < 5) m_addr[m_acnt] <= dq_o;
      m_acnt <= m_acnt + 1;
    end else if (m_busy > 0) begin
      m_busy <= m_busy - 1;
    end
    if (re) begin
      m_idx <= m_idx + 1;
      if (!rb) re_busy_bad <= re_busy_bad + 1;
    end
  end

  // ---------------- monitors ----------------
  int         log_n = 0;
  int         log_k [16];
  logic [7:0] log_b [16];
  int         rx_n = 0, rx_bad = 0, done_n = 0, ce_bad = 0, ce_seen = 0, latch_bad = 0, hold_bad = 0;
  int         exp_mode = 0;
  logic [23:0] exp_page = '0;
  logic [3:0] exp_ce = '0;
  bit         prev_stall = 1'b0;
  logic [7:0] prev_dat = '0;

  always @(posedge clk) begin
    if (rst_n) begin
      if (we) begin
        if (log_n < 16) begin
          log_k[log_n] = cle ? 1 : (ale ? 2 : 0);
          log_b[log_n] = dq_o;
        end
        log_n++;
      end
      if ((cle || ale) != we || (cle && ale)) latch_bad++;
      if (ce != 4'b0) begin
        ce_seen++;
        if (ce != exp_ce) ce_bad++;
      end
      if (done) done_n++;
      if (dat_valid && dat_ready) begin
        if (exp_mode == 1 && dat != id_byte(rx_n)) rx_bad++;
        if (exp_mode == 2 && dat != page_byte(exp_page, rx_n)) rx_bad++;
        if (exp_mode == 0) rx_bad++;
        rx_n++;
      end
      if (prev_stall && (!dat_valid || dat != prev_dat)) hold_bad++;
      prev_stall = dat_valid && !dat_ready;
      prev_dat   = dat;
    end
  end

  int rdy_pct = 100;
  initial forever begin
    @(negedge clk);
    dat_ready = ($urandom_range(0, 99) < rdy_pct);
  end

  // ---------------- operation task ----------------
  task automatic run_op(input int op, input int chip, input logic [23:0] page,
                        input bit stuck, input bit exp_err, input bit poke);
    int         ek [16];
    logic [7:0] eb [16];
    int         en, exp_rx, mism;
    string      rq;
    rq = (op == 0) ? "R3" : ((op == 1) ? "R4" : "R5");
    en = 0;
    ek[en] = 1; eb[en] = (op == 0) ? 8'hFF : ((op == 1) ? 8'h90 : 8'h00); en++;
    if (op == 1) begin ek[en] = 2; eb[en] = 8'h00; en++; end
    if (op == 2) begin
      ek[en] = 2; eb[en] = 8'h00; en++;
      ek[en] = 2; eb[en] = 8'h00; en++;
      ek[en] = 2; eb[en] = page[7:0]; en++;
      ek[en] = 2; eb[en] = page[15:8]; en++;
      ek[en] = 2; eb[en] = page[23:16]; en++;
      ek[en] = 1; eb[en] = 8'h30; en++;
    end
    exp_rx = stuck ? 0 : ((op == 1) ? 5 : ((op == 2) ? LEN : 0));

    @(negedge clk);
    while (!req_ready) @(negedge clk);
    log_n = 0; rx_n = 0; rx_bad = 0; done_n = 0; ce_bad = 0; ce_seen = 0;
    latch_bad = 0; hold_bad = 0; re_busy_bad = 0;
    exp_mode = stuck ? 0 : ((op == 1) ? 1 : ((op == 2) ? 2 : 0));
    exp_page = page; exp_ce = 4'b1 << chip;
    m_stuck = stuck; busy_len = $urandom_range(0, 40);
    req_valid = 1'b1; req_op = 2'(op); req_chip = 2'(chip); req_page = page;
    @(negedge clk);
    if (poke) begin
      req_op = 2'd0; req_page = ~page;
      repeat (20) @(negedge clk);
    end
    req_valid = 1'b0;
    while (done_n == 0) @(negedge clk);
    @(negedge clk);

    chk(log_n == en, rq, "cmd/addr byte count", log_n, en);
    mism = 0;
    for (int i = 0; i < en && i < 16; i++)
      if (log_k[i] != ek[i] || log_b[i] != eb[i]) mism++;
    chk(mism == 0, rq, "cmd/addr sequence mismatches", mism, 0);
    chk(rx_n == exp_rx, (op == 1) ? "R4" : "R5", "bytes delivered", rx_n, exp_rx);
    chk(rx_bad == 0, "R10", "data mismatches", rx_bad, 0);
    chk(hold_bad == 0, "R10", "stall hold violations", hold_bad, 0);
    chk(ce_bad == 0 && ce_seen > 0, "R2", "chip select bad cycles", ce_bad, 0);
    chk(ce == 4'b0 && req_ready, "R2", "idle after done ce", int'(ce), 0);
    chk(done_n == 1, "R11", "done pulses", done_n, 1);
    chk(latch_bad == 0, "R7", "latch/strobe violations", latch_bad, 0);
    chk(re_busy_bad == 0, "R6", "reads while busy", re_busy_bad, 0);
    chk(err == exp_err, stuck ? "R8" : "R9", "err flag", int'(err), int'(exp_err));
    m_stuck = 1'b0;
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    errs++; checks++;
    $display("FAIL R11 watchdog expired: actual=hung expected=done");
    finish_run();
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    chk(ce == 4'b0 && !cle && !ale && !we && !re, "R1", "bus idle in reset",
        int'({ce, cle, ale, we, re}), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(req_ready && !done && !err && !dat_valid, "R1", "status after reset",
        int'({req_ready, done, err, dat_valid}), 8);

    rdy_pct = 100;
    run_op(0, 0, 24'h0, 1'b0, 1'b0, 1'b0);                 // R3
    run_op(1, 1, 24'h0, 1'b0, 1'b0, 1'b0);                 // R4
    rdy_pct = 50;
    run_op(2, 2, 24'($urandom), 1'b0, 1'b0, 1'b1);         // R5, R11 ignored request
    rdy_pct = 100;
    run_op(2, 3, 24'hFFFFFF, 1'b0, 1'b0, 1'b0);            // R5 all-ones row
    for (int n = 0; n < 4; n++) begin
      rdy_pct = $urandom_range(20, 100);
      run_op($urandom_range(0, 1), $urandom_range(0, 3), 24'h0, 1'b0, 1'b0, 1'b0);
    end
    run_op(0, 0, 24'h0, 1'b1, 1'b1, 1'b0);                 // R8 timeout
    run_op(1, 2, 24'h0, 1'b0, 1'b1, 1'b0);                 // R9 sticky
    rdy_pct = 30;
    run_op(2, 1, 24'h000000, 1'b0, 1'b1, 1'b0);            // R9, R10 heavy stall

    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!err, "R9", "err cleared by reset", int'(err), 0);
    finish_run();
  end
endmodule